// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

An eight-pin general-purpose I/O port controller with a small synchronous register bus. Software sets each pin's direction and output value through registers, and reads back either the stored output value or the live pad levels. The pad side of the block carries, for every pin, the drive value, the output enable, the pull-up request and the open-drain flag. It also takes in the pad input, which is passed through a two-stage synchroniser before it can be read.

Two alternate functions can take over pins from plain I/O. The first is a display-segment driver. A mask register gives that driver ownership of chosen pins. An owned pin never gets an output enable or a pull-up, and it reads as zero. The second is a serial peripheral that supplies the drive value on a fixed group of pins (4, 5 and 6 by default). That group can also be switched to open-drain drive. The segment driver, the serial peripheral and the analog pad are outside this block and are seen only as plain inputs and outputs.

Pull-ups are controlled by a port-wide enable bit, which resets to off. A pull-up is also forced off on any pin that is set as an output.

Top module: `gpio8_ctrl`

## Requirements
- R1: After reset every direction bit is 1 (all pins inputs), the output latch is 0, pull-ups and open-drain are disabled and no pin is segment-owned; so pad_oe_o, pad_pu_o, pad_out_o, pad_od_o and pad_seg_o are all 0.
- R2: Register address 0 holds the direction bits, one per pin; bit value 1 means input and 0 means output. Writing 0xCF gives pad_oe_o = 0x30 when no alternate function is active.
- R3: A write to address 1 (latch) or to address 2 (pin) stores the write data in the output latch. Reading address 1 returns the latch. Outside the serial pins, or while the serial peripheral is idle, pad_out_o equals the latch.
- R4: Reading address 2 returns the pad input after a two-flop synchroniser. A level held for three cycles is returned by a read issued in the third cycle.
- R5: Address 3 bit 0 is the port-wide pull-up enable. pad_pu_o[i] is 1 only when that bit is 1, pin i is an input and pin i is not segment-owned.
- R6: Address 4 is the segment-ownership mask and is copied to pad_seg_o. An owned pin has pad_oe_o and pad_pu_o at 0 and reads as 0 at address 2.
- R7: While ser_active_i is 1, pad_out_o on the serial pins (mask SER_MASK, default 0x70) comes from ser_do_i instead of the latch.
- R8: Address 3 bit 1 selects open-drain. While it is set and ser_active_i is 1, pad_od_o is 1 on the serial pins and 0 elsewhere. A serial pin then has its output enable only while its drive value is 0.
- R9: The latch is not changed by direction writes, so a pin switched to output drives the value most recently written to the latch.
- R10: Read data appears on bus_rdata_o one cycle after the address is presented, and reflects register state from before any write in that same cycle. Addresses 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 3 | Register address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | WIDTH | Write data |
| bus_rdata_o | output | WIDTH | Registered read data |
| pad_in_i | input | WIDTH | Raw pad input levels |
| ser_active_i | input | 1 | Serial peripheral drives its pins |
| ser_do_i | input | WIDTH | Serial peripheral drive values (serial pins used) |
| pad_out_o | output | WIDTH | Per-pin drive value |
| pad_oe_o | output | WIDTH | Per-pin output enable |
| pad_pu_o | output | WIDTH | Per-pin weak pull-up enable |
| pad_od_o | output | WIDTH | Per-pin open-drain mode flag |
| pad_seg_o | output | WIDTH | Per-pin segment-driver ownership |

## Verification
The pad outputs are combinational functions of the registers. A corrupted direction, latch, segment or configuration bit therefore shows at pad_oe_o, pad_pu_o, pad_out_o or pad_seg_o on the first sample after the clock edge that corrupted it. A wrong bus read path shows one cycle after the read address is presented. A fault in the synchroniser shows at the pin-read address only about three cycles after a pad change, so pad levels are held long enough before such a read is checked. Open-drain faults appear only when the serial peripheral is active and a serial pin is driven high, and the stimulus covers that combination both with the direction bits set to output and with them set to input.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_DIR = 3'd0;
    localparam logic [REG_AW-1:0] RA_LAT = 3'd1;
    localparam logic [REG_AW-1:0] RA_PIN = 3'd2;
    localparam logic [REG_AW-1:0] RA_CFG = 3'd3;
    localparam logic [REG_AW-1:0] RA_SEG = 3'd4;

    localparam int unsigned CFG_PU_BIT = 0;
    localparam int unsigned CFG_OD_BIT = 1;

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (!rst_ni) chain_q[g] <= '0;
            else         chain_q[g] <= chain_d[g];
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
    import gpio8_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_AW-1:0] addr_i,
    input  logic              we_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [WIDTH-1:0]  pin_sync_i,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  lat_o,
    output logic [WIDTH-1:0]  seg_o,
    output logic              pu_en_o,
    output logic              od_en_o,
    output logic [WIDTH-1:0]  rdata_o
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] seg;
        logic             pu_en;
        logic             od_en;
        logic [WIDTH-1:0] rdata;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        // read path works on state before this cycle's write
        s_d.rdata = '0;
        unique case (addr_i)
            RA_DIR: s_d.rdata = s_q.dir;
            RA_LAT: s_d.rdata = s_q.lat;
            RA_PIN: s_d.rdata = pin_sync_i & ~s_q.seg;
            RA_CFG: begin
                s_d.rdata[CFG_PU_BIT] = s_q.pu_en;
                s_d.rdata[CFG_OD_BIT] = s_q.od_en;
            end
            RA_SEG: s_d.rdata = s_q.seg;
            default: s_d.rdata = '0;
        endcase

        if (we_i) begin
            unique case (addr_i)
                RA_DIR: s_d.dir = wdata_i;
                RA_LAT,
                RA_PIN: s_d.lat = wdata_i;
                RA_CFG: begin
                    s_d.pu_en = wdata_i[CFG_PU_BIT];
                    s_d.od_en = wdata_i[CFG_OD_BIT];
                end
                RA_SEG: s_d.seg = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.dir   <= '1;
            s_q.lat   <= '0;
            s_q.seg   <= '0;
            s_q.pu_en <= 1'b0;
            s_q.od_en <= 1'b0;
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dir_o   = s_q.dir;
    assign lat_o   = s_q.lat;
    assign seg_o   = s_q.seg;
    assign pu_en_o = s_q.pu_en;
    assign od_en_o = s_q.od_en;
    assign rdata_o = s_q.rdata;

endmodule

// File: rtl/gpio8_padmux.sv
module gpio8_padmux #(
    parameter int unsigned      WIDTH    = 8,
    parameter logic [WIDTH-1:0] SER_MASK = 8'h70
) (
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] lat_i,
    input  logic [WIDTH-1:0] seg_i,
    input  logic             pu_en_i,
    input  logic             od_en_i,
    input  logic             ser_active_i,
    input  logic [WIDTH-1:0] ser_do_i,
    output logic [WIDTH-1:0] out_o,
    output logic [WIDTH-1:0] oe_o,
    output logic [WIDTH-1:0] pu_o,
    output logic [WIDTH-1:0] od_o
);

    logic [WIDTH-1:0] val;
    logic [WIDTH-1:0] release_hi;

    always_comb begin
        val = lat_i;
        if (ser_active_i) begin
            val = (lat_i & ~SER_MASK) | (ser_do_i & SER_MASK);
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        if (SER_MASK[i]) begin : g_ser
            assign od_o[i]       = od_en_i & ser_active_i;
            assign release_hi[i] = od_o[i] & val[i];
        end else begin : g_plain
            assign od_o[i]       = 1'b0;
            assign release_hi[i] = 1'b0;
        end
        assign oe_o[i] = ~dir_i[i] & ~seg_i[i] & ~release_hi[i];
        assign pu_o[i] = pu_en_i & dir_i[i] & ~seg_i[i];
    end

    assign out_o = val;

endmodule

// File: rtl/gpio8_ctrl.sv
module gpio8_ctrl
    import gpio8_pkg::*;
#(
    parameter int unsigned      WIDTH    = 8,
    parameter logic [WIDTH-1:0] SER_MASK = 8'h70
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_AW-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    input  logic [WIDTH-1:0]  pad_in_i,
    input  logic              ser_active_i,
    input  logic [WIDTH-1:0]  ser_do_i,
    output logic [WIDTH-1:0]  pad_out_o,
    output logic [WIDTH-1:0]  pad_oe_o,
    output logic [WIDTH-1:0]  pad_pu_o,
    output logic [WIDTH-1:0]  pad_od_o,
    output logic [WIDTH-1:0]  pad_seg_o
);

    localparam int unsigned SYNC_STAGES = 2;

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dir_w;
    logic [WIDTH-1:0] lat_w;
    logic [WIDTH-1:0] seg_w;
    logic             pu_en_w;
    logic             od_en_w;

    gpio8_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (pad_in_i),
        .sync_o  (pin_sync)
    );

    gpio8_regs #(.WIDTH(WIDTH)) regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (bus_addr_i),
        .we_i       (bus_we_i),
        .wdata_i    (bus_wdata_i),
        .pin_sync_i (pin_sync),
        .dir_o      (dir_w),
        .lat_o      (lat_w),
        .seg_o      (seg_w),
        .pu_en_o    (pu_en_w),
        .od_en_o    (od_en_w),
        .rdata_o    (bus_rdata_o)
    );

    gpio8_padmux #(.WIDTH(WIDTH), .SER_MASK(SER_MASK)) mux_i (
        .dir_i        (dir_w),
        .lat_i        (lat_w),
        .seg_i        (seg_w),
        .pu_en_i      (pu_en_w),
        .od_en_i      (od_en_w),
        .ser_active_i (ser_active_i),
        .ser_do_i     (ser_do_i),
        .out_o        (pad_out_o),
        .oe_o         (pad_oe_o),
        .pu_o         (pad_pu_o),
        .od_o         (pad_od_o)
    );

    assign pad_seg_o = seg_w;

endmodule

// File: rtl/gpio8_chk.sv
module gpio8_chk
    import gpio8_pkg::*;
#(
    parameter int unsigned      WIDTH    = 8,
    parameter logic [WIDTH-1:0] SER_MASK = 8'h70
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [REG_AW-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [WIDTH-1:0]  bus_wdata_i,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  lat_q,
    input logic [WIDTH-1:0]  pad_out_o,
    input logic [WIDTH-1:0]  pad_oe_o,
    input logic [WIDTH-1:0]  pad_pu_o,
    input logic [WIDTH-1:0]  pad_od_o,
    input logic [WIDTH-1:0]  pad_seg_o
);

    logic lat_wr;
    assign lat_wr = bus_we_i && (bus_addr_i == RA_LAT || bus_addr_i == RA_PIN);

    p_seg_no_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_oe_o & pad_seg_o) == '0);

    p_pullup_inputs_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_pu_o & ~dir_q) == '0);

    p_od_never_drives_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_oe_o & pad_od_o & pad_out_o) == '0);

    p_od_serial_pins_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pad_od_o & ~SER_MASK) == '0);

    p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == RA_DIR) |=> dir_q == $past(bus_wdata_i));

    p_lat_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lat_wr |=> lat_q == $past(bus_wdata_i));

    p_lat_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lat_wr |=> $stable(lat_q));

endmodule

bind gpio8_ctrl gpio8_chk #(.WIDTH(WIDTH), .SER_MASK(SER_MASK)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .dir_q       (dir_w),
    .lat_q       (lat_w),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .pad_pu_o    (pad_pu_o),
    .pad_od_o    (pad_od_o),
    .pad_seg_o   (pad_seg_o)
);

// File: tb/gpio8_ctrl_tb.sv
module gpio8_ctrl_tb_top;

    localparam int   CLK_PERIOD = 10;
    localparam logic [7:0] SM   = 8'h70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] pad_in = '0;
    logic       ser_act = 1'b0;
    logic [7:0] ser_do = '0;
    logic [7:0] pad_out, pad_oe, pad_pu, pad_od, pad_seg;

    int vectors = 0;
    int errors  = 0;

    logic [7:0] m_dir, m_lat, m_seg;
    logic       m_pu, m_od;
    int         pad_age;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio8_ctrl dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .bus_addr_i   (addr),
        .bus_we_i     (we),
        .bus_wdata_i  (wdata),
        .bus_rdata_o  (rdata),
        .pad_in_i     (pad_in),
        .ser_active_i (ser_act),
        .ser_do_i     (ser_do),
        .pad_out_o    (pad_out),
        .pad_oe_o     (pad_oe),
        .pad_pu_o     (pad_pu),
        .pad_od_o     (pad_od),
        .pad_seg_o    (pad_seg)
    );

    function automatic logic [7:0] exp_val();
        return ser_act ? ((m_lat & ~SM) | (ser_do & SM)) : m_lat;
    endfunction

    function automatic logic [7:0] exp_od();
        return (m_od && ser_act) ? SM : 8'h00;
    endfunction

    function automatic logic [7:0] exp_oe();
        return ~m_dir & ~m_seg & ~(exp_od() & exp_val());
    endfunction

    function automatic logic [7:0] exp_pu();
        return m_pu ? (m_dir & ~m_seg) : 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_dir;
            3'd1: return m_lat;
            3'd2: return pad_in & ~m_seg;
            3'd3: return {6'b0, m_od, m_pu};
            3'd4: return m_seg;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_dir = 8'hFF; m_lat = 8'h00; m_seg = 8'h00; m_pu = 1'b0; m_od = 1'b0;
    endtask

    task automatic check_pads();
        check("R3/R7 pad_out", pad_out, exp_val());
        check("R2/R6/R8 pad_oe", pad_oe, exp_oe());
        check("R5/R6 pad_pu", pad_pu, exp_pu());
        check("R8 pad_od", pad_od, exp_od());
        check("R6 pad_seg", pad_seg, m_seg);
    endtask

    // one bus cycle, started and finished at a falling edge
    task automatic cyc(input logic [2:0] a, input logic w, input logic [7:0] d,
                       input logic [7:0] pin, input logic sa, input logic [7:0] sd);
        logic [7:0] erd;
        logic       rd_ok;
        addr = a; we = w; wdata = d; ser_act = sa; ser_do = sd;
        if (pin !== pad_in) begin
            pad_in = pin; pad_age = 0;
        end else if (pad_age < 100) begin
            pad_age++;
        end
        erd   = exp_read(a);
        rd_ok = (a != 3'd2) || (pad_age >= 2);
        if (w) begin
            case (a)
                3'd0: m_dir = d;
                3'd1, 3'd2: m_lat = d;
                3'd3: begin m_pu = d[0]; m_od = d[1]; end
                3'd4: m_seg = d;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        if (rd_ok) check("R4/R10 bus read", rdata, erd);
        check_pads();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; we = 1'b0; addr = '0; ser_act = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        // R1: reset state at the pads
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_od", pad_od, 8'h00);
        check("R1 pad_seg", pad_seg, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        pad_age = 0;
        model_reset();
        @(negedge clk);
        do_reset();

        cyc(3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
        check("R1 dir reads all ones", rdata, 8'hFF);

        cyc(3'd0, 1'b1, 8'hCF, 8'h00, 1'b0, 8'h00);
        check("R2 oe for 0xCF", pad_oe, 8'h30);

        cyc(3'd2, 1'b1, 8'hA5, 8'h00, 1'b0, 8'h00);
        check("R3 pad_out after pin write", pad_out, 8'hA5);
        cyc(3'd1, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
        check("R3 latch readback", rdata, 8'hA5);

        cyc(3'd3, 1'b1, 8'h01, 8'h00, 1'b0, 8'h00);
        check("R5 pull-ups on inputs", pad_pu, 8'hCF);

        cyc(3'd4, 1'b1, 8'h01, 8'hFF, 1'b0, 8'h00);
        check("R6 owned pin no pull-up", pad_pu, 8'hCE);
        cyc(3'd0, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00);
        cyc(3'd2, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00);
        check("R4/R6 pin read masked", rdata, 8'hFE);

        cyc(3'd0, 1'b1, 8'h00, 8'hFF, 1'b0, 8'h00);
        check("R9 all outputs, owned pin off", pad_oe, 8'hFE);
        check("R9 latch kept", pad_out, 8'hA5);
        check("R5 pull-ups off on outputs", pad_pu, 8'h00);

        cyc(3'd3, 1'b1, 8'h03, 8'hFF, 1'b1, 8'h50);
        check("R7 serial drive value", pad_out, 8'hD5);
        check("R8 open-drain release", pad_oe, 8'hAE);
        check("R8 open-drain flags", pad_od, 8'h70);
        cyc(3'd3, 1'b1, 8'h01, 8'hFF, 1'b1, 8'h50);
        check("R8 push-pull serial", pad_oe, 8'hFE);

        cyc(3'd6, 1'b1, 8'hFF, 8'hFF, 1'b0, 8'h00);
        cyc(3'd6, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00);
        check("R10 unmapped reads zero", rdata, 8'h00);
        cyc(3'd0, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00);
        check("R10 dir untouched", rdata, 8'h00);

        for (int n = 0; n < 4000; n++) begin
            logic [7:0] p;
            p = ($urandom % 6 == 0) ? 8'($urandom) : pad_in;
            cyc(3'($urandom), ($urandom % 3) != 0, 8'($urandom), p,
                1'($urandom), 8'($urandom));
        end

        do_reset();
        cyc(3'd0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
        check("R1 dir after second reset", rdata, 8'hFF);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule